// File: doc/BRIEF.md
# Issue-Advanced Mixed-Precision Multiply Pipeline

This block is a three-step integer multiply pipeline with no clock of its own progress. The pipeline moves only when an instruction stream hands it a new multiply, or when a flush request drains it. Each accepted issue loads fresh operands into the first slot and, in the same step, returns the product that leaves the final step. That product goes to the destination tag of the issue that pushed it out, not to the tag of the instruction that started it. Software therefore retrieves the last products by issuing filler multiplies with dummy operands and a dummy destination.

Operations come in two precisions. A single multiplies the low `SW` bits of each operand. A double multiplies the full `DW` bits and holds each slot it enters for two cycles, so busy is raised and further issues are refused until the slot frees up. When the precision of an accepted issue differs from that of the youngest operation in flight, one in-flight product is dropped. Switching towards double drops the product that is leaving, and switching towards single drops the youngest one. A flush input drains whatever remains, one product per free cycle, and a done flag reports an empty pipe.

Top module: `mpipe_mul`

## Requirements
- R1: A single issued into an empty pipe comes out on the second later accepted push. Three steps separate operands from result: two holding slots and the result register.
- R2: The result register is updated in the cycle after a push. `res_tag` equals the tag of the pushing issue, or 0 when the push comes from a flush.
- R3: A single (`iss_dp`=0) yields the product of bits [SW-1:0] of both operands, with the upper operand bits ignored. A double (`iss_dp`=1) yields the full DW-by-DW product on `res_data`.
- R4: After a double is accepted, `busy` is high for one cycle. An issue presented while `busy` is high is ignored and never reaches the result port.
- R5: Doubles issued two cycles apart deliver the first one's product with the third issue, at cycle 4 when the first is issued at cycle 0.
- R6: An accepted single whose youngest in-flight operation is a double still returns the leaving double. The younger double is discarded, so the next push returns an invalid result.
- R7: An accepted double whose youngest in-flight operation is a single discards the leaving single, giving an invalid result. The next push returns the most recent single.
- R8: A push whose leaving slot is empty or discarded drives `res_vld`=0 and `res_data`=0.
- R9: Synchronous reset empties the pipe: `flush_done`=1, `busy`=0, `res_vld`=0. An issue into an empty pipe gives an invalid result.
- R10: While `flush` is high, issues are ignored. Each non-busy cycle with a valid slot pushes a bubble and returns the leaving product with tag 0, and `flush_done` rises once no slot is valid.
- R11: Without an accepted issue or a flush, the pipe does not advance: `res_vld` stays 0 and `res_data`/`res_tag` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_vld | input | 1 | Issue request for a pipelined multiply |
| iss_dp | input | 1 | Precision of the issue: 1 double, 0 single |
| iss_a | input | DW | First operand |
| iss_b | input | DW | Second operand |
| iss_tag | input | TW | Destination tag of the issuing instruction |
| flush | input | 1 | Drain request; blocks new issues |
| busy | output | 1 | A double still holds its slot; issues are refused |
| res_vld | output | 1 | Result register holds a real product this cycle |
| res_data | output | 2*DW | Product delivered by the last push |
| res_tag | output | TW | Destination the product is written to |
| flush_done | output | 1 | No slot holds a valid operation |

## Verification
The hardest states to reach are the precision switches. Each one needs a specific mix of precisions already in flight, and only the issue port can place it there, with the double spacing kept. The bench builds these states in order. A chain of doubles, with an ignored issue placed in the busy gap, leaves two doubles in flight. A single then forces the switch towards single, and further singles refill the pipe. A double with an idle gap then forces the switch back towards double. Each discarded slot is seen as an invalid, zero result one push later, and the surviving product is seen with the tag of the issue that retrieved it.

// File: rtl/mpipe_pkg.sv
package mpipe_pkg;

    // cycles a double holds each slot it enters
    localparam int DP_OCC = 2;
    localparam int HOLD_W = (DP_OCC > 2) ? $clog2(DP_OCC) : 1;

    typedef enum logic {
        PREC_SP = 1'b0,
        PREC_DP = 1'b1
    } prec_e;

    typedef struct packed {
        logic              vld;
        prec_e             prec;
        logic [HOLD_W-1:0] hold;
    } slot_stat_t;

endpackage

// File: rtl/mpipe_pp.sv
// One partial-product step: (a * b) shifted into place in the product width.
module mpipe_pp #(
    parameter int AW = 16,
    parameter int BW = 8,
    parameter int SH = 0,
    parameter int PW = 32
) (
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    output logic [PW-1:0] p
);
    logic [AW+BW-1:0] raw;

    always_comb begin
        raw = a * b;
    end

    assign p = PW'(raw) << SH;
endmodule

// File: rtl/mpipe_ctrl.sv
// Issue control: decides acceptance, draining and precision-switch discards.
module mpipe_ctrl
    import mpipe_pkg::*;
#(
    parameter int NS = 2
) (
    input  slot_stat_t [NS-1:0] stat,
    input  logic                iss_vld,
    input  prec_e               iss_prec,
    input  logic                flush,
    output logic                busy,
    output logic                take_new,
    output logic                push,
    output logic                drop_old,
    output logic                drop_young,
    output logic                empty
);
    logic [NS-1:0] live;
    logic [NS-1:0] held;
    logic          prec_switch;

    for (genvar g = 0; g < NS; g++) begin : g_slot
        assign live[g] = stat[g].vld;
        assign held[g] = stat[g].vld && (stat[g].prec == PREC_DP) && (stat[g].hold != '0);
    end

    always_comb begin
        busy        = |held;
        empty       = ~|live;
        take_new    = iss_vld && !flush && !busy;
        push        = take_new || (flush && !busy && !empty);
        prec_switch = take_new && stat[0].vld && (stat[0].prec != iss_prec);
        drop_old    = prec_switch && (iss_prec == PREC_DP);
        drop_young  = prec_switch && (iss_prec == PREC_SP);
    end
endmodule

// File: rtl/mpipe_mul.sv
module mpipe_mul
    import mpipe_pkg::*;
#(
    parameter int DW = 16,
    parameter int SW = 8,
    parameter int TW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            iss_vld,
    input  logic            iss_dp,
    input  logic [DW-1:0]   iss_a,
    input  logic [DW-1:0]   iss_b,
    input  logic [TW-1:0]   iss_tag,
    input  logic            flush,
    output logic            busy,
    output logic            res_vld,
    output logic [2*DW-1:0] res_data,
    output logic [TW-1:0]   res_tag,
    output logic            flush_done
);
    localparam int NS = 2;
    localparam int H  = DW / 2;
    localparam int PW = 2 * DW;
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(DP_OCC - 1);
    localparam logic [DW-1:0] OP_MASK = {{(DW-SW){1'b0}}, {SW{1'b1}}};
    localparam logic [PW-1:0] PR_MASK = {{(PW-2*SW){1'b0}}, {(2*SW){1'b1}}};

    typedef struct packed {
        slot_stat_t [NS-1:0] stat;
        logic [DW-1:0]       s0_a;
        logic [DW-H-1:0]     s0_bhi;
        logic [PW-1:0]       s0_acc;
        logic [PW-1:0]       s1_acc;
        logic                r_vld;
        logic [PW-1:0]       r_data;
        logic [TW-1:0]       r_tag;
    } st_t;

    st_t st_d, st_q;

    prec_e         iss_prec;
    logic          take_new, push, drop_old, drop_young, empty;
    logic [DW-1:0] a_in, b_in;
    logic [PW-1:0] lo_p, hi_p, fin_p;

    assign iss_prec = iss_dp ? PREC_DP : PREC_SP;
    assign a_in     = iss_dp ? iss_a : (iss_a & OP_MASK);
    assign b_in     = iss_dp ? iss_b : (iss_b & OP_MASK);

    mpipe_ctrl #(.NS(NS)) u_ctrl (
        .stat       (st_q.stat),
        .iss_vld    (iss_vld),
        .iss_prec   (iss_prec),
        .flush      (flush),
        .busy       (busy),
        .take_new   (take_new),
        .push       (push),
        .drop_old   (drop_old),
        .drop_young (drop_young),
        .empty      (empty)
    );

    // step 1: low half of the multiplier
    mpipe_pp #(.AW(DW), .BW(H), .SH(0), .PW(PW)) u_pp_lo (
        .a (a_in),
        .b (b_in[H-1:0]),
        .p (lo_p)
    );

    // step 2: high half of the multiplier
    mpipe_pp #(.AW(DW), .BW(DW-H), .SH(H), .PW(PW)) u_pp_hi (
        .a (st_q.s0_a),
        .b (st_q.s0_bhi),
        .p (hi_p)
    );

    // step 3: precision trim on the way into the result register
    assign fin_p = (st_q.stat[1].prec == PREC_DP) ? st_q.s1_acc : (st_q.s1_acc & PR_MASK);

    always_comb begin
        st_d       = st_q;
        st_d.r_vld = 1'b0;
        for (int i = 0; i < NS; i++) begin
            if (st_q.stat[i].hold != '0) begin
                st_d.stat[i].hold = st_q.stat[i].hold - HOLD_W'(1);
            end
        end
        if (push) begin
            st_d.r_vld          = st_q.stat[1].vld && !drop_old;
            st_d.r_data         = st_d.r_vld ? fin_p : '0;
            st_d.r_tag          = take_new ? iss_tag : '0;
            st_d.stat[1].vld    = st_q.stat[0].vld && !drop_young;
            st_d.stat[1].prec   = st_q.stat[0].prec;
            st_d.stat[1].hold   = (st_q.stat[0].prec == PREC_DP) ? HOLD_LOAD : '0;
            st_d.s1_acc         = st_q.s0_acc + hi_p;
            st_d.stat[0].vld    = take_new;
            st_d.stat[0].prec   = iss_prec;
            st_d.stat[0].hold   = iss_dp ? HOLD_LOAD : '0;
            st_d.s0_a           = a_in;
            st_d.s0_bhi         = b_in[DW-1:H];
            st_d.s0_acc         = lo_p;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_vld    = st_q.r_vld;
    assign res_data   = st_q.r_data;
    assign res_tag    = st_q.r_tag;
    assign flush_done = empty;
endmodule

// File: rtl/mpipe_mul_chk.sv
module mpipe_mul_chk #(
    parameter int PW = 32,
    parameter int TW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          iss_vld,
    input logic          iss_dp,
    input logic          flush,
    input logic          busy,
    input logic          res_vld,
    input logic [PW-1:0] res_data,
    input logic [TW-1:0] res_tag,
    input logic          flush_done
);
    // R4
    busy_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !res_vld);

    // R4
    dp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_vld && iss_dp && !busy && !flush) |=> busy);

    // R10
    flush_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (flush && flush_done) |=> (!res_vld && flush_done));

    // R11
    no_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (!(iss_vld && !busy) && !flush) |=> (!res_vld && $stable(res_tag) && $stable(res_data)));

    // R9
    empty_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (flush_done && iss_vld && !flush) |=> !res_vld);

    // R9
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (flush_done && !busy && !res_vld));
endmodule

bind mpipe_mul mpipe_mul_chk #(.PW(2*DW), .TW(TW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .iss_vld    (iss_vld),
    .iss_dp     (iss_dp),
    .flush      (flush),
    .busy       (busy),
    .res_vld    (res_vld),
    .res_data   (res_data),
    .res_tag    (res_tag),
    .flush_done (flush_done)
);

// File: tb/mpipe_mul_bench.sv
module mpipe_mul_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    localparam logic [15:0] TA [NV] = '{16'h12F3, 16'hA507, 16'h00FF, 16'h3C81, 16'hFF00, 16'h7E42, 16'h0199, 16'hBEEF};
    localparam logic [15:0] TB [NV] = '{16'h4411, 16'h9C0D, 16'h00FF, 16'h0102, 16'h55AA, 16'h2B37, 16'hF0E5, 16'h1357};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iss_vld = 1'b0;
    logic        iss_dp = 1'b0;
    logic [15:0] iss_a = '0;
    logic [15:0] iss_b = '0;
    logic [3:0]  iss_tag = '0;
    logic        flush = 1'b0;
    logic        busy, res_vld, flush_done;
    logic [31:0] res_data;
    logic [3:0]  res_tag;
    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpipe_mul u_mpipe_mul (
        .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_dp(iss_dp),
        .iss_a(iss_a), .iss_b(iss_b), .iss_tag(iss_tag), .flush(flush),
        .busy(busy), .res_vld(res_vld), .res_data(res_data),
        .res_tag(res_tag), .flush_done(flush_done)
    );

    function automatic logic [31:0] sp(input logic [15:0] a, input logic [15:0] b);
        return 32'(a[7:0]) * 32'(b[7:0]);
    endfunction

    function automatic logic [31:0] dp(input logic [15:0] a, input logic [15:0] b);
        return 32'(a) * 32'(b);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_res(input string req, input bit v, input logic [31:0] d, input logic [3:0] t);
        chk(res_vld == v, {req, " valid"}, 64'(res_vld), 64'(v));
        chk(res_data == d, {req, " data"}, 64'(res_data), 64'(d));
        if (v) chk(res_tag == t, {req, " tag"}, 64'(res_tag), 64'(t));
    endtask

    // starts and ends at a falling edge; outputs reflect the push on return
    task automatic issue(input bit p, input logic [15:0] a, input logic [15:0] b, input logic [3:0] t);
        iss_vld = 1'b1; iss_dp = p; iss_a = a; iss_b = b; iss_tag = t;
        @(negedge clk);
        iss_vld = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] hold_d;
        logic [3:0]  hold_t;
        @(negedge clk);
        do_reset();
        // R9: reset state
        chk(flush_done == 1'b1, "R9 reset flush_done", 64'(flush_done), 64'd1);
        chk(busy == 1'b0, "R9 reset busy", 64'(busy), 64'd0);
        chk(res_vld == 1'b0, "R9 reset res_vld", 64'(res_vld), 64'd0);

        // R1 R2 R3 R9: stream of singles from the table
        for (int i = 0; i < NV; i++) begin
            issue(1'b0, TA[i], TB[i], 4'(i + 1));
            if (i < 2) chk_res("R9 empty pipe", 1'b0, 32'd0, 4'd0);
            else       chk_res("R1 R2 R3 single stream", 1'b1, sp(TA[i-2], TB[i-2]), 4'(i + 1));
        end

        // R11: no advance while idle
        hold_d = res_data;
        hold_t = res_tag;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(res_vld == 1'b0, "R11 idle res_vld", 64'(res_vld), 64'd0);
            chk(res_data == hold_d && res_tag == hold_t, "R11 idle hold", 64'({res_tag, res_data}), 64'({hold_t, hold_d}));
        end

        // R10: flush drains the two remaining singles, issue ignored
        flush = 1'b1; iss_vld = 1'b1; iss_dp = 1'b0; iss_a = 16'h00EE; iss_b = 16'h00DD; iss_tag = 4'hF;
        @(negedge clk);
        chk_res("R10 drain first", 1'b1, sp(TA[6], TB[6]), 4'd0);
        chk(flush_done == 1'b0, "R10 not done", 64'(flush_done), 64'd0);
        @(negedge clk);
        chk_res("R10 drain second", 1'b1, sp(TA[7], TB[7]), 4'd0);
        chk(flush_done == 1'b1, "R10 done", 64'(flush_done), 64'd1);
        @(negedge clk);
        chk(res_vld == 1'b0, "R10 empty flush", 64'(res_vld), 64'd0);
        flush = 1'b0; iss_vld = 1'b0;
        issue(1'b0, 16'h0005, 16'h0006, 4'd1);
        chk_res("R10 ignored issue absent 1", 1'b0, 32'd0, 4'd0);
        issue(1'b0, 16'h0007, 16'h0008, 4'd2);
        chk_res("R10 ignored issue absent 2", 1'b0, 32'd0, 4'd0);

        // R4 R5: chained doubles with an ignored issue in the busy gap
        do_reset();
        issue(1'b1, 16'hC35A, 16'h8E21, 4'd5);
        chk(busy == 1'b1, "R4 busy after double", 64'(busy), 64'd1);
        issue(1'b1, 16'hFFFF, 16'hFFFF, 4'd9);
        chk(res_vld == 1'b0 && busy == 1'b0, "R4 busy issue refused", 64'({busy, res_vld}), 64'd0);
        issue(1'b1, 16'h0003, 16'h0003, 4'd0);
        @(negedge clk);
        issue(1'b1, 16'h0101, 16'h0202, 4'd7);
        chk_res("R5 first double at third issue", 1'b1, dp(16'hC35A, 16'h8E21), 4'd7);
        @(negedge clk);
        issue(1'b1, 16'h0001, 16'h0001, 4'd8);
        chk_res("R4 filler follows, refused issue absent", 1'b1, 32'd9, 4'd8);

        // R6 R8: double to single switch
        @(negedge clk);
        issue(1'b0, 16'h1234, 16'h5678, 4'd10);
        chk_res("R6 leaving double kept", 1'b1, dp(16'h0101, 16'h0202), 4'd10);
        issue(1'b0, 16'h00AB, 16'h00CD, 4'd11);
        chk_res("R6 R8 younger double dropped", 1'b0, 32'd0, 4'd0);

        // R7 R8: single to double switch
        issue(1'b0, 16'h0011, 16'h0022, 4'd12);
        chk_res("R7 single before switch", 1'b1, sp(16'h1234, 16'h5678), 4'd12);
        issue(1'b1, 16'h7777, 16'h3333, 4'd13);
        chk_res("R7 R8 leaving single dropped", 1'b0, 32'd0, 4'd0);
        @(negedge clk);
        issue(1'b1, 16'h0002, 16'h0002, 4'd14);
        chk_res("R7 recent single stored", 1'b1, sp(16'h0011, 16'h0022), 4'd14);

        finish_run();
    end
endmodule